// File: doc/BRIEF.md
# Two-Stage PN Code Acquisition Searcher

This block finds the code phase of a direct-sequence spread-spectrum pilot during initial acquisition. Signed I/Q chip samples arrive with a local PN chip, one per valid sample. Each sample is despread by that chip and summed coherently over a configurable number of chips. A single energy figure is formed from the two coherent sums. The energy goes through a cheap first test. Only if that test passes does the block spend a longer second stage, which sums the energies of several further dwells without regard to phase and tests the total against a second threshold.

A failure in either stage produces a one-cycle slip pulse. The external PN generator uses that pulse to retard its phase by one chip, and the block's chip-offset counter advances with it. A pass of the second stage raises a sticky lock flag. The offset counter then freezes and shows the phase where lock was found. A start pulse begins a new search from offset zero.

To cut hardware, the energy is the square of the larger of the two coherent magnitudes, so only one squarer is needed. The larger magnitude is picked by a multiplexer steered from the two bits just below the always-zero sign bit of each magnitude. A full-width compare is used only when those bits match. Coherent sums are kept in carry-save form and resolved once per dwell.

Top module: `pn_acq_searcher`

## Requirements
- R1: After reset, slip and locked are 0, chip_offset is 0, and no sample is taken until start is pulsed.
- R2: While accumulating, each valid sample is despread: pn_chip 0 adds the sample, pn_chip 1 adds its negation. A dwell ends after exactly cfg_nc accepted samples. cfg_nc and cfg_nn are 1 or more.
- R3: The coherent sums cannot overflow, even for cfg_nc = 255 with every sample at -128 and pn_chip 1, which gives a sum of +32640 on both arms. The non-coherent total cannot overflow either.
- R4: The dwell energy equals M*M, where M is the larger of |sum_I| and |sum_Q|.
- R5: The larger magnitude is chosen from the two bits just below each magnitude's zero sign bit (bits 15:14 at the default widths). When those bit pairs are equal, a full compare decides. In every case the pick is the true maximum.
- R6: A first-stage dwell passes only if its energy is strictly greater than cfg_thr1. A first-stage failure slips.
- R7: After a first-stage pass, cfg_nn further dwells are run and their energies summed. If the sum is strictly greater than cfg_thr2, the block locks. Otherwise it slips and returns to the first stage.
- R8: A slip is a one-cycle pulse on slip, and chip_offset increments by one in the same cycle. slip and the lock rise of locked start in the cycle after the second clock edge following the edge that accepts a dwell's last sample.
- R9: Once locked, locked stays 1, chip_offset holds, and further samples have no effect until start.
- R10: start, in any state, clears locked and chip_offset, returns to the first stage and begins a fresh dwell.
- R11: Valid samples presented during the two evaluation cycles after a dwell's last sample are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new search from offset zero |
| cfg_nc | input | 8 | Chips per coherent dwell |
| cfg_nn | input | 4 | Dwells summed in the second stage |
| cfg_thr1 | input | 34 | First-stage energy threshold |
| cfg_thr2 | input | 38 | Second-stage total threshold |
| smp_valid | input | 1 | A sample and its PN chip are present |
| smp_i | input | 8 | Signed in-phase chip sample |
| smp_q | input | 8 | Signed quadrature chip sample |
| pn_chip | input | 1 | Local PN chip: 0 means +1, 1 means -1 |
| slip | output | 1 | One-cycle request to retard the PN phase one chip |
| locked | output | 1 | Acquisition succeeded |
| chip_offset | output | 10 | Chips slipped since start; holds the lock phase |

## Verification
The bench goes after the strict-inequality edges of both tests, with energies and totals exactly equal to a threshold. A design using greater-or-equal would lock or advance a stage one dwell early. It drives magnitude pairs that the top-bit precompute decides and pairs that need the full compare. A wrong fallback would square the smaller arm and misjudge a stage. It runs a full-scale dwell of -128 samples with negating chips, where a narrow accumulator would wrap to a tiny or negative energy. It also feeds garbage samples in the evaluation gap and after lock; a design that took them would corrupt the next sum or move the held offset.

// File: rtl/pn_acq_pkg.sv
// Shared types for the PN acquisition searcher.
package pn_acq_pkg;
    typedef enum logic [2:0] {
        SRCH_IDLE,   // waiting for start
        SRCH_ACC,    // coherent accumulation of one dwell
        SRCH_ENG,    // resolve sums and register energy
        SRCH_DEC,    // stage decision
        SRCH_HOLD    // locked
    } srch_state_t;
endpackage

// File: rtl/pn_csa_accum.sv
// Coherent accumulator kept in carry-save form.
// Each accepted input is merged with one row of full adders; the sum is
// resolved by one carry-propagate add on the output. Assumes W holds the
// largest possible sum, so arithmetic modulo 2^W gives the exact result.
module pn_csa_accum #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] total
);
    logic [W-1:0] sum_r, car_r, car_sh, sum_nx, car_nx;

    assign car_sh = {car_r[W-2:0], 1'b0};

    // one full adder per bit: three inputs in, sum and carry out
    for (genvar b = 0; b < W; b++) begin : g_fa
        assign sum_nx[b] = sum_r[b] ^ car_sh[b] ^ din[b];
        assign car_nx[b] = (sum_r[b] & car_sh[b]) | (sum_r[b] & din[b]) | (car_sh[b] & din[b]);
    end

    // hold the redundant pair; clear wins over accumulate
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_r <= '0;
            car_r <= '0;
        end else if (en) begin
            sum_r <= sum_nx;
            car_r <= car_nx;
        end
    end

    assign total = sum_r + car_sh;
endmodule

// File: rtl/pn_mag_select.sv
// Picks the larger of |a| and |b| for the single squarer.
// Assumes the magnitudes fit in W-1 bits, so bit W-1 of each is zero.
// The two bits below that bit decide the pick when they differ; otherwise
// a full-width compare decides.
module pn_mag_select #(
    parameter int W = 17
) (
    input  logic [W-1:0] sum_a,
    input  logic [W-1:0] sum_b,
    output logic [W-1:0] mag_max
);
    logic [W-1:0] mag_a, mag_b;
    logic [1:0]   top_a, top_b;
    logic         a_wins;

    // absolute values and precompute decision, then a plain mux
    always_comb begin
        mag_a  = sum_a[W-1] ? (~sum_a + 1'b1) : sum_a;
        mag_b  = sum_b[W-1] ? (~sum_b + 1'b1) : sum_b;
        top_a  = mag_a[W-2:W-3];
        top_b  = mag_b[W-2:W-3];
        if (top_a != top_b) a_wins = (top_a > top_b);
        else                a_wins = (mag_a >= mag_b);
        mag_max = a_wins ? mag_a : mag_b;
    end
endmodule

// File: rtl/pn_dwell_ctrl.sv
// Dwell sequencer: counts chips, runs the two-stage test, slips or locks.
// Assumes cfg_nc and cfg_nn are at least 1 and stay constant between starts.
// energy is valid from the edge after energy_load.
module pn_dwell_ctrl
    import pn_acq_pkg::*;
#(
    parameter int NC_W  = 8,
    parameter int NN_W  = 4,
    parameter int E_W   = 34,
    parameter int NS_W  = 38,
    parameter int OFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             smp_valid,
    input  logic [NC_W-1:0]  cfg_nc,
    input  logic [NN_W-1:0]  cfg_nn,
    input  logic [E_W-1:0]   cfg_thr1,
    input  logic [NS_W-1:0]  cfg_thr2,
    input  logic [E_W-1:0]   energy,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             energy_load,
    output logic             slip,
    output logic             locked,
    output logic [OFF_W-1:0] chip_offset
);
    srch_state_t     state;
    logic            stage2;
    logic [NC_W-1:0] chip_cnt;
    logic [NN_W-1:0] dwell_cnt;
    logic [NS_W-1:0] nsum, nsum_nx;

    assign acc_en      = (state == SRCH_ACC) && smp_valid && !start;
    assign acc_clr     = start || (state == SRCH_DEC);
    assign energy_load = (state == SRCH_ENG);
    assign nsum_nx     = nsum + NS_W'(energy);
    assign locked      = (state == SRCH_HOLD);

    // main sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SRCH_IDLE;
            stage2      <= 1'b0;
            chip_cnt    <= '0;
            dwell_cnt   <= '0;
            nsum        <= '0;
            slip        <= 1'b0;
            chip_offset <= '0;
        end else if (start) begin
            state       <= SRCH_ACC;
            stage2      <= 1'b0;
            chip_cnt    <= '0;
            dwell_cnt   <= '0;
            nsum        <= '0;
            slip        <= 1'b0;
            chip_offset <= '0;
        end else begin
            slip <= 1'b0;
            case (state)
                SRCH_ACC: begin
                    if (smp_valid) begin
                        if (chip_cnt == cfg_nc - NC_W'(1)) begin
                            chip_cnt <= '0;
                            state    <= SRCH_ENG;
                        end else begin
                            chip_cnt <= chip_cnt + NC_W'(1);
                        end
                    end
                end
                SRCH_ENG: state <= SRCH_DEC;
                SRCH_DEC: begin
                    if (!stage2) begin
                        if (energy > cfg_thr1) begin
                            stage2    <= 1'b1;
                            dwell_cnt <= '0;
                            nsum      <= '0;
                            state     <= SRCH_ACC;
                        end else begin
                            slip        <= 1'b1;
                            chip_offset <= chip_offset + OFF_W'(1);
                            state       <= SRCH_ACC;
                        end
                    end else if (dwell_cnt == cfg_nn - NN_W'(1)) begin
                        stage2 <= 1'b0;
                        if (nsum_nx > cfg_thr2) begin
                            state <= SRCH_HOLD;
                        end else begin
                            slip        <= 1'b1;
                            chip_offset <= chip_offset + OFF_W'(1);
                            state       <= SRCH_ACC;
                        end
                    end else begin
                        dwell_cnt <= dwell_cnt + NN_W'(1);
                        nsum      <= nsum_nx;
                        state     <= SRCH_ACC;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    AST_SLIP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) slip |=> !slip); // R8
    AST_SLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n) slip |-> chip_offset == $past(chip_offset) + OFF_W'(1)); // R8
    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (locked && !start) |=> (locked && $stable(chip_offset))); // R9
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n) !(slip && locked)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (state == SRCH_DEC && stage2) |-> nsum_nx >= nsum); // R3
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) start |=> (!locked && chip_offset == '0)); // R10
endmodule

// File: rtl/pn_acq_searcher.sv
// Two-stage PN acquisition searcher, top level.
// Despreads I/Q samples, keeps coherent sums per arm, squares the larger
// magnitude into a registered energy and hands it to the dwell sequencer.
// Assumes the external PN generator retards one chip per slip pulse.
module pn_acq_searcher #(
    parameter int SAMP_W = 8,
    parameter int NC_W   = 8,
    parameter int NN_W   = 4,
    parameter int OFF_W  = 10,
    localparam int ACC_W = SAMP_W + NC_W + 1,
    localparam int E_W   = 2 * ACC_W,
    localparam int NS_W  = E_W + NN_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NC_W-1:0]          cfg_nc,
    input  logic [NN_W-1:0]          cfg_nn,
    input  logic [E_W-1:0]           cfg_thr1,
    input  logic [NS_W-1:0]          cfg_thr2,
    input  logic                     smp_valid,
    input  logic signed [SAMP_W-1:0] smp_i,
    input  logic signed [SAMP_W-1:0] smp_q,
    input  logic                     pn_chip,
    output logic                     slip,
    output logic                     locked,
    output logic [OFF_W-1:0]         chip_offset
);
    logic [SAMP_W-1:0] raw   [2];
    logic [ACC_W-1:0]  coh   [2];
    logic [ACC_W-1:0]  mag_max;
    logic [E_W-1:0]    energy_r;
    logic              acc_clr, acc_en, energy_load;

    assign raw[0] = smp_i;
    assign raw[1] = smp_q;

    // per-arm despreader and carry-save coherent accumulator
    for (genvar ch = 0; ch < 2; ch++) begin : g_arm
        logic [ACC_W-1:0] ext, desp;
        assign ext  = {{(ACC_W-SAMP_W){raw[ch][SAMP_W-1]}}, raw[ch]};
        assign desp = pn_chip ? (~ext + 1'b1) : ext;
        pn_csa_accum #(.W(ACC_W)) i_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (acc_clr),
            .en    (acc_en),
            .din   (desp),
            .total (coh[ch])
        );
    end

    pn_mag_select #(.W(ACC_W)) i_sel (
        .sum_a   (coh[0]),
        .sum_b   (coh[1]),
        .mag_max (mag_max)
    );

    // single squarer; energy registered once per dwell
    always_ff @(posedge clk) begin
        if (!rst_n)           energy_r <= '0;
        else if (energy_load) energy_r <= E_W'(mag_max) * E_W'(mag_max);
    end

    pn_dwell_ctrl #(
        .NC_W (NC_W), .NN_W (NN_W), .E_W (E_W), .NS_W (NS_W), .OFF_W (OFF_W)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .smp_valid   (smp_valid),
        .cfg_nc      (cfg_nc),
        .cfg_nn      (cfg_nn),
        .cfg_thr1    (cfg_thr1),
        .cfg_thr2    (cfg_thr2),
        .energy      (energy_r),
        .acc_clr     (acc_clr),
        .acc_en      (acc_en),
        .energy_load (energy_load),
        .slip        (slip),
        .locked      (locked),
        .chip_offset (chip_offset)
    );

    // plain magnitudes, used only to check the precomputed pick
    logic [ACC_W-1:0] chk_abs_i, chk_abs_q;
    assign chk_abs_i = coh[0][ACC_W-1] ? (~coh[0] + 1'b1) : coh[0];
    assign chk_abs_q = coh[1][ACC_W-1] ? (~coh[1] + 1'b1) : coh[1];

    AST_MAX_PICK: assert property (@(posedge clk) disable iff (!rst_n) energy_load |-> (mag_max >= chk_abs_i && mag_max >= chk_abs_q)); // R5
    AST_SIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n) energy_load |-> !mag_max[ACC_W-1]); // R3
    AST_ENERGY_HELD: assert property (@(posedge clk) disable iff (!rst_n) !energy_load |=> $stable(energy_r)); // R4
endmodule

// File: tb/test_pn_acq_searcher.sv
module test_pn_acq_searcher;
    localparam int SAMP_W = 8, NC_W = 8, NN_W = 4, OFF_W = 10;
    localparam int ACC_W = SAMP_W + NC_W + 1;
    localparam int E_W = 2 * ACC_W, NS_W = E_W + NN_W;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [NC_W-1:0] cfg_nc = '0;
    logic [NN_W-1:0] cfg_nn = '0;
    logic [E_W-1:0]  cfg_thr1 = '0;
    logic [NS_W-1:0] cfg_thr2 = '0;
    logic smp_valid = 1'b0, pn_chip = 1'b0;
    logic signed [SAMP_W-1:0] smp_i = '0, smp_q = '0;
    logic slip, locked;
    logic [OFF_W-1:0] chip_offset;

    always #5 clk = ~clk;

    pn_acq_searcher i_pn_acq_searcher (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_nc(cfg_nc), .cfg_nn(cfg_nn),
        .cfg_thr1(cfg_thr1), .cfg_thr2(cfg_thr2), .smp_valid(smp_valid),
        .smp_i(smp_i), .smp_q(smp_q), .pn_chip(pn_chip),
        .slip(slip), .locked(locked), .chip_offset(chip_offset)
    );

    typedef struct { bit is_lock; int off; string req; } exp_t;
    exp_t sb[$];
    int n_chk = 0, n_fail = 0;

    // reference model state
    int m_stage = 0, m_dcnt = 0, m_off = 0, m_nn = 1;
    longint m_nsum = 0, m_t1 = 0, m_t2 = 0;

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(int nc, int nn, longint t1, longint t2);
        cfg_nc = NC_W'(nc); cfg_nn = NN_W'(nn);
        cfg_thr1 = E_W'(t1); cfg_thr2 = NS_W'(t2);
        m_stage = 0; m_dcnt = 0; m_off = 0; m_nn = nn; m_nsum = 0; m_t1 = t1; m_t2 = t2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // model one dwell outcome from the requirements (R6, R7)
    task automatic model_step(longint e);
        exp_t it;
        if (m_stage == 0) begin
            if (e > m_t1) begin m_stage = 1; m_dcnt = 0; m_nsum = 0; end
            else begin
                m_off = (m_off + 1) % (1 << OFF_W);
                it.is_lock = 0; it.off = m_off; it.req = "R6"; sb.push_back(it);
            end
        end else begin
            m_nsum += e;
            if (m_dcnt == m_nn - 1) begin
                m_stage = 0;
                if (m_nsum > m_t2) begin it.is_lock = 1; it.off = m_off; it.req = "R7"; end
                else begin
                    m_off = (m_off + 1) % (1 << OFF_W);
                    it.is_lock = 0; it.off = m_off; it.req = "R7";
                end
                sb.push_back(it);
            end else m_dcnt++;
        end
    endtask

    // drive one dwell, then two garbage samples in the evaluation gap (R11)
    task automatic run_dwell(int nc, int vi, int vq, bit rip, bit full);
        longint si = 0, sq = 0, mi, mq, m;
        for (int k = 0; k < nc; k++) begin
            int r, pn, ri, rq;
            r  = rip ? (k % 3) - 1 : 0;
            pn = full ? 1 : ((k ^ (k >> 2)) & 1);
            ri = full ? -128 : (pn ? -(vi + r) : (vi + r));
            rq = full ? -128 : (pn ? -(vq + r) : (vq + r));
            smp_valid = 1'b1; pn_chip = pn[0];
            smp_i = SAMP_W'(ri); smp_q = SAMP_W'(rq);
            si += pn ? -ri : ri;   // R2 despread
            sq += pn ? -rq : rq;
            @(negedge clk);
        end
        mi = si < 0 ? -si : si;
        mq = sq < 0 ? -sq : sq;
        m  = mi > mq ? mi : mq;    // R4, R5
        model_step(m * m);
        for (int g = 0; g < 2; g++) begin
            smp_valid = 1'b1; pn_chip = g[0];
            smp_i = 8'sd127; smp_q = -8'sd128;
            @(negedge clk);
        end
        smp_valid = 1'b0;
    endtask

    // scoreboard monitor
    logic lk_q = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (slip || (locked && !lk_q)) begin
                if (sb.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R8 actual=unexpected %s expected=none", slip ? "slip" : "lock");
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    chk({it.req, " kind"}, longint'(locked), longint'(it.is_lock));
                    chk({it.req, " R8 offset"}, longint'(chip_offset), longint'(it.off));
                end
            end
        end
        lk_q <= locked;
    end

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, samples before start ignored
        smp_valid = 1'b1; smp_i = 8'sd50;
        repeat (5) @(negedge clk);
        smp_valid = 1'b0;
        chk("R1 slip", longint'(slip), 0);
        chk("R1 locked", longint'(locked), 0);
        chk("R1 offset", longint'(chip_offset), 0);

        // A: stage 1 fail, stage 2 fail, then lock (R6, R7)
        do_start(16, 3, 10000, 200000);
        run_dwell(16, 5, 3, 1, 0);
        run_dwell(16, 20, -30, 1, 0);
        run_dwell(16, 10, 0, 1, 0);
        run_dwell(16, 10, 0, 1, 0);
        run_dwell(16, 10, 0, 1, 0);
        run_dwell(16, 30, 20, 1, 0);
        run_dwell(16, -40, 25, 1, 0);
        run_dwell(16, -40, 25, 1, 0);
        run_dwell(16, -40, 25, 1, 0);
        // R9: extra samples after lock change nothing
        smp_valid = 1'b1; smp_i = 8'sd100; smp_q = -8'sd100;
        repeat (20) @(negedge clk);
        smp_valid = 1'b0;
        chk("R9 locked", longint'(locked), 1);
        chk("R9 offset", longint'(chip_offset), 2);

        // B: R10 restart, threshold equality edges, full-compare fallback
        do_start(4, 1, 1600, 1936);
        chk("R10 locked", longint'(locked), 0);
        chk("R10 offset", longint'(chip_offset), 0);
        run_dwell(4, 10, -10, 0, 0);   // energy 1600 == thr1: slip (R6)
        run_dwell(4, 10, 11, 0, 0);    // 1936 passes, Q wins by full compare (R5)
        run_dwell(4, 11, 10, 0, 0);    // total 1936 == thr2: slip (R7)
        run_dwell(4, 11, 10, 0, 0);
        run_dwell(4, -12, 0, 0, 0);    // 2304 > 1936: lock
        repeat (2) @(negedge clk);
        chk("R7 lock offset", longint'(chip_offset), 2);

        // C: large sums decided by top-bit precompute, one by fallback (R5)
        do_start(200, 2, 100000000, 700000000);
        run_dwell(200, 100, 2, 1, 0);
        run_dwell(200, 3, -101, 1, 0);
        run_dwell(200, 90, -95, 1, 0);
        repeat (2) @(negedge clk);
        chk("R5 locked", longint'(locked), 1);

        // D: full-scale dwell, no overflow (R3)
        do_start(255, 1, 1065369599, 1065369599);
        run_dwell(255, 0, 0, 0, 1);
        run_dwell(255, 0, 0, 0, 1);
        repeat (2) @(negedge clk);
        chk("R3 locked", longint'(locked), 1);
        chk("R3 offset", longint'(chip_offset), 0);

        repeat (4) @(negedge clk);
        chk("R8 pending events", longint'(sb.size()), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule